// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the processor side of exception entry. A request carries the byte address of a vector slot in the low table. The block waits for the instruction-boundary strobe and then saves the running context on the stack, one byte per cycle. It then reads the two-byte vector from the slot and hands the resulting address to the program counter. The current PC, system condition byte, code bank byte and stack pointer arrive as inputs. The block samples them at the edge where it starts, so later changes to them have no effect on the bytes it saves.

The number of bytes saved depends on the mode input. Minimum mode saves three bytes and maximum mode saves four, because the code bank byte is saved only in maximum mode. The vector holds only a 16-bit address inside a bank. Software must therefore place the first instructions of every handler in the common region at the bottom of the address space.

The block holds one request that arrives while a sequence is running, and it starts that request at the first boundary after the running sequence ends. Instruction decoding and the return path are handled elsewhere.

Top module: `exc_entry_seq`

## Requirements
- R1: A sequence starts only at a rising clock edge where `insn_done` is 1 and a request is present, either held from earlier or arriving on `req_valid` in that same cycle. Without `insn_done` the block stays idle: `busy` and all strobes remain 0.
- R2: In minimum mode (`max_mode`=0) the block writes exactly three stack bytes on consecutive cycles. The order is PC[15:8], then PC[7:0], then SC.
- R3: In maximum mode (`max_mode`=1) the block writes exactly four stack bytes. The order is CB, then PC[15:8], then PC[7:0], then SC.
- R4: The stack pointer is decremented before each write. The bytes go to SP-1, SP-2 and onward, and when the sequence ends `sp_out` equals the sampled SP minus the number of bytes written.
- R5: After the last push, `mem_re` is high for two cycles. The address is the zero-extended slot in the first cycle and slot+1 in the second. Read data is expected on `mem_rdata` one cycle after each read strobe.
- R6: `pc_out` becomes {byte at slot+1, byte at slot}. `done` is a single-cycle pulse in cycle N+4 after the start edge, where N is the number of bytes pushed.
- R7: A request that arrives while the block is busy is held and starts at the first `insn_done` after `done`. The held slot is used. A further request that arrives while one is already held is dropped.
- R8: After reset, `busy`, `done`, `stk_we` and `mem_re` are 0, and `pc_out` and `sp_out` are 0.
- R9: Slot 0x00, the reset vector, and slot 0xFE, the top slot, are read at addresses 0x000000/0x000001 and 0x0000FE/0x0000FF.
- R10: The PC, SC, CB and SP bytes saved are the values present at the start edge. Changes to them after that edge do not alter the bytes written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request strobe |
| req_slot | input | 8 | Vector slot byte address (even) |
| insn_done | input | 1 | Current instruction has completed |
| max_mode | input | 1 | 1 = maximum mode (bank byte is saved) |
| cur_pc | input | 16 | Running program counter |
| cur_sc | input | 8 | Running system condition byte |
| cur_cb | input | 8 | Running code bank byte |
| cur_sp | input | 24 | Running stack pointer |
| stk_we | output | 1 | Stack byte write strobe |
| stk_addr | output | 24 | Stack write address |
| stk_wdata | output | 8 | Stack write data |
| sp_out | output | 24 | Stack pointer after the pushes so far |
| mem_re | output | 1 | Vector read strobe |
| mem_addr | output | 24 | Vector read address |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |
| pc_out | output | 16 | Handler start address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | PC loaded (one cycle) |

## Verification
The start edge is the edge that samples `insn_done` together with a request. The bench takes it as cycle zero and counts falling edges from it. Pushes are due in cycles 1 to N, the two vector reads in cycles N+1 and N+2, and `done` with the new `pc_out` in cycle N+4. Each stack write and read strobe is logged on the falling edge when it occurs, and the log is compared afterwards with the expected order and addresses. The count of falling edges at which `done` first appears must equal N+4 exactly. The context inputs are scrambled just after the start edge, so any late sampling shows up in the saved bytes.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PUSH = 3'd1,
    ST_RDLO = 3'd2,
    ST_RDHI = 3'd3,
    ST_WAIT = 3'd4,
    ST_DONE = 3'd5
  } seq_st_e;

  // Context byte order on the stack: the first entry is pushed first.
  localparam int unsigned CTX_BYTES = 4;
  localparam logic [1:0]  IDX_CB    = 2'd0;
  localparam logic [1:0]  IDX_PCH   = 2'd1;
  localparam logic [1:0]  IDX_PCL   = 2'd2;
  localparam logic [1:0]  IDX_SC    = 2'd3;
endpackage

// File: rtl/exc_req_hold.sv
module exc_req_hold #(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic              take,
  output logic              pend,
  output logic [SLOT_W-1:0] slot_sel
);
  logic              pend_q, pend_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    pend_d = pend_q;
    slot_d = slot_q;
    if (take) begin
      // The held request is consumed; a new one arriving now gets held.
      pend_d = pend_q & req_valid;
      if (pend_q && req_valid) slot_d = req_slot;
    end else if (!pend_q && req_valid) begin
      pend_d = 1'b1;
      slot_d = req_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      slot_q <= '0;
    end else begin
      pend_q <= pend_d;
      slot_q <= slot_d;
    end
  end

  assign pend     = pend_q | req_valid;
  assign slot_sel = pend_q ? slot_q : req_slot;

  // R7: while a request is held and not consumed, its slot is kept.
  assert_held_slot_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take) |=> (pend_q && slot_q == $past(slot_q)));
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend,
  input  logic       insn_done,
  input  logic       max_mode,
  output seq_st_e    st,
  output logic [1:0] byte_idx,
  output logic       take
);
  seq_st_e    st_q, st_d;
  logic [1:0] idx_q, idx_d;

  assign take = (st_q == ST_IDLE) && pend && insn_done;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: if (take) begin
        st_d  = ST_PUSH;
        idx_d = max_mode ? IDX_CB : IDX_PCH;
      end
      ST_PUSH: begin
        idx_d = idx_q + 2'd1;
        if (idx_q == IDX_SC) st_d = ST_RDLO;
      end
      ST_RDLO: st_d = ST_RDHI;
      ST_RDHI: st_d = ST_WAIT;
      ST_WAIT: st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= IDX_CB;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign st       = st_q;
  assign byte_idx = idx_q;

  // R1: the push phase is entered only after a boundary strobe.
  assert_start_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PUSH && $past(st_q) == ST_IDLE) |-> $past(insn_done));
  // R3: the first byte depends on the mode seen at the start edge.
  assert_first_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PUSH && $past(st_q) == ST_IDLE) |->
      (idx_q == ($past(max_mode) ? IDX_CB : IDX_PCH)));
endmodule

// File: rtl/exc_ctx_push.sv
module exc_ctx_push
  import exc_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  seq_st_e           st,
  input  logic [1:0]        byte_idx,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [7:0]        cur_sc,
  input  logic [7:0]        cur_cb,
  input  logic [ADDR_W-1:0] cur_sp,
  output logic              stk_we,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [7:0]        stk_wdata,
  output logic [ADDR_W-1:0] sp_out
);
  localparam int unsigned PC_HI = PC_W - 1;
  localparam int unsigned PC_LO = PC_W - 8;

  logic [7:0]        ctx_in [CTX_BYTES];
  logic [7:0]        ctx_q  [CTX_BYTES];
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic              push;

  always_comb begin
    ctx_in[IDX_CB]  = cur_cb;
    ctx_in[IDX_PCH] = cur_pc[PC_HI:PC_LO];
    ctx_in[IDX_PCL] = cur_pc[7:0];
    ctx_in[IDX_SC]  = cur_sc;
  end

  generate
    for (genvar gi = 0; gi < CTX_BYTES; gi++) begin : g_ctx
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ctx_q[gi] <= '0;
        else if (take) ctx_q[gi] <= ctx_in[gi];
      end
    end
  endgenerate

  assign push = (st == ST_PUSH);

  always_comb begin
    sp_d = sp_q;
    if (take)      sp_d = cur_sp;
    else if (push) sp_d = sp_q - ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  assign stk_we    = push;
  assign stk_addr  = sp_q - ADDR_W'(1);
  assign stk_wdata = ctx_q[byte_idx];
  assign sp_out    = sp_q;

  // R4: after each write the stack pointer equals the address just written.
  assert_sp_predec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |=> (sp_out == $past(stk_addr)));
endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch
  import exc_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  seq_st_e           st,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic [7:0]        mem_rdata,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PC_W-1:0]   pc_out
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [7:0]        lo_q, lo_d;
  logic [PC_W-1:0]   pc_q, pc_d;

  always_comb begin
    slot_d = take ? slot_sel : slot_q;
    lo_d   = (st == ST_RDHI) ? mem_rdata : lo_q;
    pc_d   = (st == ST_WAIT) ? {mem_rdata, lo_q} : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      lo_q   <= '0;
      pc_q   <= '0;
    end else begin
      slot_q <= slot_d;
      lo_q   <= lo_d;
      pc_q   <= pc_d;
    end
  end

  assign mem_re   = (st == ST_RDLO) || (st == ST_RDHI);
  assign mem_addr = ADDR_W'(slot_q) + ADDR_W'(st == ST_RDHI);
  assign pc_out   = pc_q;

  // R5: the low-byte read is followed at once by the read of the next byte.
  assert_vec_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RDLO) |=> (mem_re && mem_addr == $past(mem_addr) + ADDR_W'(1)));
  // R6: the PC changes only when the high byte arrives.
  assert_pc_only_on_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_WAIT) |=> $stable(pc_out));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic              insn_done,
  input  logic              max_mode,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [7:0]        cur_sc,
  input  logic [7:0]        cur_cb,
  input  logic [ADDR_W-1:0] cur_sp,
  output logic              stk_we,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [7:0]        stk_wdata,
  output logic [ADDR_W-1:0] sp_out,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic [PC_W-1:0]   pc_out,
  output logic              busy,
  output logic              done
);
  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              pend_w, take_w;
  logic [SLOT_W-1:0] slot_w;
  logic [1:0]        idx_w;
  seq_st_e           st_w;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  exc_req_hold #(.SLOT_W(SLOT_W)) u_hold (
    .clk(clk), .rst_n(rst_i_n), .req_valid(req_valid), .req_slot(req_slot),
    .take(take_w), .pend(pend_w), .slot_sel(slot_w)
  );

  exc_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .pend(pend_w), .insn_done(insn_done),
    .max_mode(max_mode), .st(st_w), .byte_idx(idx_w), .take(take_w)
  );

  exc_ctx_push #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_push (
    .clk(clk), .rst_n(rst_i_n), .take(take_w), .st(st_w), .byte_idx(idx_w),
    .cur_pc(cur_pc), .cur_sc(cur_sc), .cur_cb(cur_cb), .cur_sp(cur_sp),
    .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata), .sp_out(sp_out)
  );

  exc_vec_fetch #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .PC_W(PC_W)) u_vec (
    .clk(clk), .rst_n(rst_i_n), .take(take_w), .st(st_w), .slot_sel(slot_w),
    .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_addr(mem_addr), .pc_out(pc_out)
  );

  assign busy = (st_w != ST_IDLE);
  assign done = (st_w == ST_DONE);

  // R6: the completion strobe lasts one cycle.
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);
  // R5: stack writes and vector reads never overlap.
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(stk_we && mem_re));
  // R7: a request seen while busy leaves a pending request behind.
  assert_busy_req_held_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && req_valid) |=> pend_w);
endmodule

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  localparam logic       V_MAX  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [7:0] V_SLOT [NV] = '{8'h00, 8'h04, 8'h1E, 8'hFE, 8'h26};
  localparam logic [15:0] V_PC  [NV] = '{16'h1234, 16'hBEEF, 16'h0001, 16'h7FFE, 16'hA55A};
  localparam logic [7:0] V_SC   [NV] = '{8'hC3, 8'h0F, 8'h80, 8'h11, 8'hE7};
  localparam logic [7:0] V_CB   [NV] = '{8'h02, 8'h9A, 8'h44, 8'h01, 8'h7C};
  localparam logic [23:0] V_SP  [NV] = '{24'h001000, 24'h00FF00, 24'h000004, 24'h123456, 24'h000200};

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, insn_done = 1'b0, max_mode = 1'b0;
  logic [7:0] req_slot = 8'h00, cur_sc = 8'h00, cur_cb = 8'h00;
  logic [15:0] cur_pc = 16'h0;
  logic [23:0] cur_sp = 24'h0;
  logic stk_we, mem_re, busy, done;
  logic [23:0] stk_addr, sp_out, mem_addr;
  logic [7:0] stk_wdata, mem_rdata = 8'h00;
  logic [15:0] pc_out;

  int checks = 0, errors = 0, cyc = 0;
  logic [23:0] wa [256];
  logic [7:0]  wd [256];
  logic [23:0] ra [256];
  int wn = 0, rn = 0;

  exc_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slot(req_slot),
    .insn_done(insn_done), .max_mode(max_mode), .cur_pc(cur_pc), .cur_sc(cur_sc),
    .cur_cb(cur_cb), .cur_sp(cur_sp), .stk_we(stk_we), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .sp_out(sp_out), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mbyte(input logic [23:0] a);
    return 8'(a[7:0] * 8'd29 + a[15:8] + 8'd5);
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= mbyte(mem_addr);

  always @(negedge clk) begin
    if (stk_we) begin wa[wn % 256] = stk_addr; wd[wn % 256] = stk_wdata; wn++; end
    if (mem_re) begin ra[rn % 256] = mem_addr; rn++; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 100000);
      summary();
    end
  end

  // Runs one sequence. fresh=1 presents a request with the boundary strobe;
  // fresh=0 relies on a held request. inj=1 sends two more requests while busy.
  task automatic run_seq(input logic mx, input logic [7:0] slot, input logic [15:0] pc,
                         input logic [7:0] sc, input logic [7:0] cb, input logic [23:0] sp,
                         input logic fresh, input logic inj, input logic [7:0] inj_slot);
    int n, k, wb, rb;
    logic [7:0] exp_b [4];
    n = mx ? 4 : 3;
    @(negedge clk);
    wb = wn; rb = rn;
    max_mode = mx; cur_pc = pc; cur_sc = sc; cur_cb = cb; cur_sp = sp;
    req_valid = fresh; req_slot = fresh ? slot : 8'h55; insn_done = 1'b1;
    @(posedge clk);
    k = 0;
    while (!done && k < 40) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        req_valid = 1'b0; insn_done = 1'b0; max_mode = ~mx;
        cur_pc = ~pc; cur_sc = ~sc; cur_cb = ~cb; cur_sp = sp ^ 24'h00F0F0;
      end
      if (inj && k == 2) begin req_valid = 1'b1; req_slot = inj_slot; end
      if (inj && k == 3) req_slot = 8'hEE;
      if (inj && k == 4) req_valid = 1'b0;
    end
    chk("R6 done cycle", k, n + 4);
    chk(mx ? "R3 push count" : "R2 push count", wn - wb, n);
    exp_b[0] = cb; exp_b[1] = pc[15:8]; exp_b[2] = pc[7:0]; exp_b[3] = sc;
    for (int i = 0; i < n; i++) begin
      chk("R4 push addr", wa[(wb + i) % 256], sp - 24'(i + 1));
      chk(mx ? "R3 R10 push data" : "R2 R10 push data", wd[(wb + i) % 256], exp_b[i + 4 - n]);
    end
    chk("R5 R9 read count", rn - rb, 2);
    chk("R5 R9 read lo addr", ra[rb % 256], {16'h0, slot});
    chk("R5 R9 read hi addr", ra[(rb + 1) % 256], {16'h0, slot} + 24'd1);
    chk("R6 pc_out", pc_out, {mbyte({16'h0, slot} + 24'd1), mbyte({16'h0, slot})});
    chk("R4 sp_out", sp_out, sp - 24'(n));
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk("R8 busy", busy, 0);
    chk("R8 done", done, 0);
    chk("R8 stk_we", stk_we, 0);
    chk("R8 mem_re", mem_re, 0);
    chk("R8 pc_out", pc_out, 0);
    chk("R8 sp_out", sp_out, 0);

    // Table of sequences walked by one loop
    for (int v = 0; v < NV; v++)
      run_seq(V_MAX[v], V_SLOT[v], V_PC[v], V_SC[v], V_CB[v], V_SP[v], 1'b1, 1'b0, 8'h00);

    // R1: request without boundary strobe does not start
    @(negedge clk);
    req_valid = 1'b1; req_slot = 8'h0A;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk("R1 idle without insn_done", {busy, stk_we, mem_re}, 0);
    end
    // Held request starts at the boundary strobe, with the held slot
    run_seq(1'b0, 8'h0A, 16'h4321, 8'h5A, 8'h33, 24'h000800, 1'b0, 1'b0, 8'h00);

    // R7: request during busy is held; a second one is dropped
    run_seq(1'b1, 8'h10, 16'hCAFE, 8'h21, 8'h06, 24'h002000, 1'b1, 1'b1, 8'h18);
    repeat (3) begin
      @(negedge clk);
      chk("R7 held not started before boundary", busy, 0);
    end
    run_seq(1'b0, 8'h18, 16'h0F0F, 8'h77, 8'h88, 24'h003000, 1'b0, 1'b0, 8'h00);
    repeat (3) begin
      @(negedge clk);
      insn_done = 1'b1;
    end
    @(negedge clk);
    chk("R7 dropped request not run", busy, 0);
    insn_done = 1'b0;
    summary();
  end
endmodule